// File: doc/BRIEF.md
# Expansion-ROM Licence Timeout Gate

This block sits between the console CPU bus and a cartridge that can accept a plug-in expansion ROM. It decides, for every CPU access, whether the switchable 16 KiB window at $8000-$BFFF is served by the cartridge's own program ROM or by the expansion ROM. It also decides whether a read must be left undriven, so that the CPU sees open bus. The upper window at $C000-$FFFF always stays on the internal ROM.

Access to the expansion ROM is guarded by a licence watchdog that counts M2 cycles. While work RAM is disabled, software restarts the watchdog by writing anywhere in $6000-$7FFF. Expansion-ROM reads are answered only while the watchdog is still counting. Once 107520 M2 cycles have passed since the last restart, those reads float. The watchdog comes out of reset already expired. The block also forms the expansion-ROM address, and a smaller expansion image appears mirrored across the 128 KiB space.

Top module: `exp_rom_lic_gate`

## Requirements
- R1: After reset the watchdog is expired, so a read of $8000-$BFFF with the source bit (prg_ctrl[3]) at 0 raises open_bus.
- R2: A CPU write (cpu_rw = 0) to $6000-$7FFF while prg_ctrl[4] = 0 restarts the watchdog, and an expansion read in the next cycle has open_bus low.
- R3: After a restart, expansion reads have open_bus low for exactly TIMEOUT M2 cycles (default 107520) and high from then on, until the next restart.
- R4: While prg_ctrl[4] = 1 (work RAM enabled), writes to $6000-$7FFF do not restart the watchdog.
- R5: Reads of $6000-$7FFF never restart the watchdog.
- R6: ext_sel is 1 for any access to $8000-$BFFF when prg_ctrl[3] = 0 (external source), and 0 when prg_ctrl[3] = 1 (internal source).
- R7: Accesses to $C000-$FFFF always use the internal ROM: ext_sel = 0 and open_bus = 0.
- R8: Reads from the internal source in $8000-$BFFF never raise open_bus, even with the watchdog expired.
- R9: ext_addr equals the low EXT_AW bits of {prg_ctrl[2:0], cpu_addr[13:0]}, so an image smaller than 128 KiB is mirrored.
- R10: A read of $6000-$7FFF raises open_bus when prg_ctrl[4] = 0, and not when prg_ctrl[4] = 1.
- R11: Writes never raise open_bus.
- R12: A restart while the watchdog is still running begins a full new TIMEOUT period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m2 | input | 1 | CPU M2 phase clock; one rising edge per bus cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the current cycle |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| prg_ctrl | input | 5 | PRG control: [4] work RAM enable, [3] source (1 internal, 0 external), [2:0] 16 KiB bank |
| ext_sel | output | 1 | Current access to $8000-$BFFF is routed to the expansion ROM |
| ext_addr | output | EXT_AW | Expansion-ROM byte address |
| open_bus | output | 1 | Leave the data bus undriven for this read |

## Verification
The hardest condition to reach is the exact edge of the timeout. The bench restarts the watchdog, and shortly afterwards restarts it again while it is still counting. It then holds an expansion read steady through the full default period and checks the cycle just before expiry and the cycle at expiry. If the first restart were still in effect, expiry would come a thousand cycles early. The bench also applies RAM-window writes with work RAM enabled, and RAM-window reads, while the watchdog is expired, to show that neither of them brings it back.

// File: rtl/lic_pkg.sv
// Shared types for the expansion-ROM licence gate.
// Assumes a 16-bit CPU address and a 5-bit PRG control value.
package lic_pkg;

    localparam int BANK_W  = 3;   // 16 KiB bank number width
    localparam int WIN_OFS = 14;  // address bits inside a 16 KiB window

    // PRG control value as seen by this block
    typedef struct packed {
        logic              ram_en;   // 1: work RAM decodes $6000-$7FFF
        logic              src_int;  // 1: internal ROM, 0: expansion ROM
        logic [BANK_W-1:0] bank;     // 16 KiB bank for $8000-$BFFF
    } prg_ctrl_t;

    // CPU address window classes
    typedef enum logic [1:0] {
        WIN_OTHER  = 2'd0,
        WIN_RAM    = 2'd1,   // $6000-$7FFF
        WIN_SWITCH = 2'd2,   // $8000-$BFFF
        WIN_FIXED  = 2'd3    // $C000-$FFFF
    } cpu_win_e;

endpackage

// File: rtl/lic_addr_decode.sv
// Classifies the CPU address into one of the windows this block cares about.
// Purely combinational; assumes a full 16-bit address.
module lic_addr_decode
    import lic_pkg::*;
(
    input  logic [15:0] cpu_addr,
    output cpu_win_e    win
);

    // Window selection from the top address bits
    always_comb begin
        if (cpu_addr[15:14] == 2'b11)      win = WIN_FIXED;
        else if (cpu_addr[15:14] == 2'b10) win = WIN_SWITCH;
        else if (cpu_addr[15:13] == 3'b011) win = WIN_RAM;
        else                               win = WIN_OTHER;
    end

endmodule

// File: rtl/lic_timer.sv
// Licence watchdog: a saturating up-counter clocked by M2.
// A restart clears it; it counts each M2 cycle until it reaches TIMEOUT
// and then holds there. Reset leaves it holding (expired).
module lic_timer #(
    parameter int TIMEOUT = 107520
) (
    input  logic m2,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] cnt;

    assign expired = (cnt == LIMIT);

    // Counter update: reset to expired, restart to zero, else step until limit
    always_ff @(posedge m2) begin
        if (!rst_n)        cnt <= LIMIT;
        else if (restart)  cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    // R3: once expired, only a restart brings the timer back
    a_r3_saturate : assert property (@(posedge m2) disable iff (!rst_n)
        (expired && !restart) |=> expired);

    // R3: while running, the count advances by one per M2 cycle
    a_r3_step : assert property (@(posedge m2) disable iff (!rst_n)
        (!expired && !restart) |=> (cnt == $past(cnt) + 1'b1));

    // R2: a restart always leaves the timer running
    a_r2_restart : assert property (@(posedge m2) disable iff (!rst_n)
        restart |=> !expired);

endmodule

// File: rtl/lic_read_gate.sv
// Routes the switchable window to internal or expansion ROM, forms the
// expansion address (mirrored by truncation) and flags reads that must
// float. Combinational; assumes EXT_AW between 14 and 17.
module lic_read_gate
    import lic_pkg::*;
#(
    parameter int EXT_AW = 17
) (
    input  cpu_win_e          win,
    input  logic              cpu_rw,
    input  prg_ctrl_t         ctrl,
    input  logic [13:0]       win_ofs,
    input  logic              expired,
    output logic              ext_sel,
    output logic [EXT_AW-1:0] ext_addr,
    output logic              open_bus
);

    localparam int FULL_W = BANK_W + WIN_OFS;

    logic [FULL_W-1:0] full_addr;
    logic              ext_float;
    logic              ram_float;

    // Expansion address: bank above window offset, upper bits dropped
    always_comb begin
        full_addr = {ctrl.bank, win_ofs};
        ext_addr  = full_addr[EXT_AW-1:0];
    end

    // Source routing: only the switchable window can reach the expansion ROM
    always_comb ext_sel = (win == WIN_SWITCH) && !ctrl.src_int;

    // Float conditions: expired expansion read, or read of disabled RAM window
    always_comb begin
        ext_float = ext_sel && expired;
        ram_float = (win == WIN_RAM) && !ctrl.ram_en;
        open_bus  = cpu_rw && (ext_float || ram_float);
    end

endmodule

// File: rtl/exp_rom_lic_gate.sv
// Top of the expansion-ROM licence gate. Decodes the CPU address, restarts
// the licence watchdog on writes into the disabled RAM window and gates
// expansion-ROM reads once the watchdog has expired.
// Assumes one bus cycle per M2 rising edge, sampled at that edge.
module exp_rom_lic_gate
    import lic_pkg::*;
#(
    parameter int TIMEOUT = 107520,
    parameter int EXT_AW  = 17
) (
    input  logic              m2,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rw,
    input  logic [4:0]        prg_ctrl,
    output logic              ext_sel,
    output logic [EXT_AW-1:0] ext_addr,
    output logic              open_bus
);

    cpu_win_e  win;
    prg_ctrl_t ctrl;
    logic      restart;
    logic      expired;

    assign ctrl = prg_ctrl_t'(prg_ctrl);

    // Restart request: write into the RAM window while work RAM is off
    always_comb restart = (win == WIN_RAM) && !cpu_rw && !ctrl.ram_en;

    lic_addr_decode u_decode (
        .cpu_addr (cpu_addr),
        .win      (win)
    );

    lic_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .m2      (m2),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (expired)
    );

    lic_read_gate #(.EXT_AW(EXT_AW)) u_gate (
        .win      (win),
        .cpu_rw   (cpu_rw),
        .ctrl     (ctrl),
        .win_ofs  (cpu_addr[13:0]),
        .expired  (expired),
        .ext_sel  (ext_sel),
        .ext_addr (ext_addr),
        .open_bus (open_bus)
    );

    // R4: RAM-window writes with work RAM on leave an expired timer expired
    a_r4_ram_write_ignored : assert property (@(posedge m2) disable iff (!rst_n)
        ((win == WIN_RAM) && !cpu_rw && ctrl.ram_en && expired) |=> expired);

    // R8: a floating read of the switchable window implies an expired timer
    a_r8_float_needs_expiry : assert property (@(posedge m2) disable iff (!rst_n)
        (open_bus && (win == WIN_SWITCH)) |-> expired);

    // R7: the fixed window never reaches the expansion ROM or floats
    a_r7_fixed_internal : assert property (@(posedge m2) disable iff (!rst_n)
        (win == WIN_FIXED) |-> (!ext_sel && !open_bus));

    // R11: only reads float
    a_r11_write_driven : assert property (@(posedge m2) disable iff (!rst_n)
        open_bus |-> cpu_rw);

endmodule

// File: tb/test_exp_rom_lic_gate.sv
`timescale 1ns/1ps
module test_exp_rom_lic_gate;

    localparam int TIMEOUT = 107520;
    localparam int EXT_AW  = 15;

    logic              m2 = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = 16'h0000;
    logic              cpu_rw = 1'b1;
    logic [4:0]        prg_ctrl = 5'b0;
    logic              ext_sel;
    logic [EXT_AW-1:0] ext_addr;
    logic              open_bus;

    typedef struct {
        logic              ob;
        logic              es;
        logic [EXT_AW-1:0] ea;
        string             tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2.5 m2 = ~m2;

    exp_rom_lic_gate #(.TIMEOUT(TIMEOUT), .EXT_AW(EXT_AW)) i_exp_rom_lic_gate (
        .m2       (m2),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .prg_ctrl (prg_ctrl),
        .ext_sel  (ext_sel),
        .ext_addr (ext_addr),
        .open_bus (open_bus)
    );

    function automatic logic [EXT_AW-1:0] exp_addr(input logic [4:0] c, input logic [15:0] a);
        logic [16:0] full;
        full = {c[2:0], a[13:0]};
        return full[EXT_AW-1:0];
    endfunction

    // Driver: apply one bus cycle after the edge and queue its expectation
    task automatic step(input logic [15:0] a, input logic rw, input logic [4:0] c,
                        input logic ob, input logic es, input string tag);
        exp_t e;
        @(posedge m2);
        #1;
        cpu_addr = a;
        cpu_rw   = rw;
        prg_ctrl = c;
        e.ob  = ob;
        e.es  = es;
        e.ea  = exp_addr(c, a);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs mid-cycle against the queued expectation
    always @(negedge m2) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if (open_bus !== e.ob || ext_sel !== e.es || ext_addr !== e.ea) begin
                n_fail++;
                $display("FAIL %s: got ob=%b es=%b ea=%h, expected ob=%b es=%b ea=%h",
                         e.tag, open_bus, ext_sel, ext_addr, e.ob, e.es, e.ea);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge m2);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge m2);
        #1 rst_n = 1'b1;
        // R1: expired out of reset
        step(16'h8000, 1'b1, 5'b0_0_000, 1'b1, 1'b1, "R1 reset expired");
        // R10: RAM window reads float only with RAM disabled
        step(16'h6000, 1'b1, 5'b0_0_000, 1'b1, 1'b0, "R10 ram off read");
        step(16'h6000, 1'b1, 5'b1_0_000, 1'b0, 1'b0, "R10 ram on read");
        // R4: RAM-enabled write does not restart
        step(16'h6123, 1'b0, 5'b1_0_000, 1'b0, 1'b0, "R4 ram write");
        step(16'h8000, 1'b1, 5'b1_0_000, 1'b1, 1'b1, "R4 still expired");
        // R5: reads do not restart
        step(16'h7FFF, 1'b1, 5'b0_0_000, 1'b1, 1'b0, "R5 ram read");
        step(16'h8000, 1'b1, 5'b0_0_000, 1'b1, 1'b1, "R5 still expired");
        // R11: writes never float
        step(16'h8000, 1'b0, 5'b0_0_000, 1'b0, 1'b1, "R11 ext write");
        // R7: fixed window internal
        step(16'hC000, 1'b1, 5'b0_0_000, 1'b0, 1'b0, "R7 fixed low");
        step(16'hFFFF, 1'b1, 5'b0_0_111, 1'b0, 1'b0, "R7 fixed high");
        // R6 / R8: source selection
        step(16'hA000, 1'b1, 5'b0_1_010, 1'b0, 1'b0, "R8 internal read");
        step(16'hA000, 1'b1, 5'b0_0_010, 1'b1, 1'b1, "R6 external select");
        // R9: address formation and mirroring
        step(16'h9234, 1'b1, 5'b0_1_101, 1'b0, 1'b0, "R9 addr bank5");
        step(16'h8ABC, 1'b1, 5'b0_1_100, 1'b0, 1'b0, "R9 mirror bank4");
        // R2: restart opens the window next cycle
        step(16'h7000, 1'b0, 5'b0_0_000, 1'b0, 1'b0, "R2 restart write");
        step(16'h8000, 1'b1, 5'b0_0_000, 1'b0, 1'b1, "R2 readable");
        step(16'hBFFF, 1'b1, 5'b0_0_011, 1'b0, 1'b1, "R2 readable top");
        // R12: restart again mid-count
        repeat (1000) @(posedge m2);
        step(16'h6ABC, 1'b0, 5'b0_0_000, 1'b0, 1'b0, "R12 second restart");
        // R3: exact expiry edge measured from the second restart
        step(16'h8000, 1'b1, 5'b0_0_001, 1'b0, 1'b1, "R3 first cycle");
        repeat (TIMEOUT - 2) @(posedge m2);
        step(16'h8000, 1'b1, 5'b0_0_001, 1'b0, 1'b1, "R3 R12 last open cycle");
        step(16'h8000, 1'b1, 5'b0_0_001, 1'b1, 1'b1, "R3 expiry cycle");
        step(16'h8000, 1'b1, 5'b0_1_001, 1'b0, 1'b0, "R8 internal after expiry");
        @(posedge m2);
        @(negedge m2);
        #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule